// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block sits between a control path and an external 12-bit analog-to-digital converter whose input passes through a two-way multiplexer. Mux input 0 carries the current-sense amplifier output and mux input 1 carries the supply voltage. A run can be launched by a command strobe that carries channel-select bits, or by a rising edge on an asynchronous convert-start pin. The block steers the multiplexer and pulses the converter's start line. It collects each 12-bit result and raises a done flag once every requested channel has been converted.

Once done is high, the stored results appear as a short byte stream for the serial read path. The read side picks a byte by index, and a length output gives the number of valid bytes: two for a single channel, three for both. The converter itself and the serial protocol sit outside this block.

Top module: `dual_conv_seq`

## Requirements
- R1: After reset, busy, done and adc_start are 0, rd_len is 0, and rd_data is 0 for every rd_idx.
- R2: A cmd_valid pulse taken while busy is 0 starts a run if cmd_sel is nonzero. cmd_sel bit 1 selects voltage and bit 0 selects current. busy is 1 and done is 0 in the cycle after the pulse. A pulse with cmd_sel = 00 starts nothing.
- R3: After a SYNC_STAGES-flop synchronizer, a rising edge on conv_pin starts a run with the channel set PIN_SEL (default both). Holding the pin high does not start another run.
- R4: When both channels are requested, voltage (adc_mux = 1) is converted first and current (adc_mux = 0) second.
- R5: adc_start is a single-cycle pulse, and adc_mux holds the same value in the cycle before each pulse.
- R6: A command or pin edge that arrives while busy is 1 is dropped. It adds no conversion and does not change the results of the running run.
- R7: If an idle cycle sees a valid nonzero command and a pin edge together, the command's channel set is used and the pin edge is dropped.
- R8: When the result of the last requested channel arrives, busy falls and done rises in the same cycle. done stays high until the next run starts.
- R9: While done is 0, rd_data is 0 and rd_len is 0.
- R10: A single-channel result R gives rd_len = 2. Byte 0 is R[11:4], byte 1 is {R[3:0],4'h0}, and byte index 2 or 3 reads 0.
- R11: A two-channel result with voltage V and current I gives rd_len = 3. Byte 0 is V[11:4], byte 1 is I[11:4], byte 2 is {V[3:0],I[3:0]}, and index 3 reads 0.
- R12: An adc_done pulse that comes while no conversion is outstanding is ignored and leaves the stored results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe from the serial side |
| cmd_sel | input | 2 | Channel set: bit 1 voltage, bit 0 current |
| conv_pin | input | 1 | Asynchronous convert-start pin |
| adc_mux | output | 1 | Mux select: 1 voltage, 0 current |
| adc_start | output | 1 | One-cycle converter start pulse |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | 12 | Converter result, valid with adc_done |
| busy | output | 1 | Run in progress |
| done | output | 1 | All requested results stored |
| rd_idx | input | 2 | Byte index of the read stream |
| rd_data | output | 8 | Selected result byte |
| rd_len | output | 2 | Number of valid bytes (0, 2 or 3) |

## Verification
Two triggers can land in the same cycle: the command strobe and the synchronized pin edge. The bench raises the pin and then, exactly SYNC_STAGES falling edges later, drives a current-only command, so the edge detector and the strobe are seen at the same rising edge. The outcome is judged from the result length and bytes, and the scoreboard confirms that only one current conversion was started. Triggers that overlap a running sequence are provoked the same way, and any stray start pulse shows up as an unexpected item in the scoreboard.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = RES_W - BYTE_W;

    typedef logic [RES_W-1:0]  res_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // channel request: volt is converted before cur
    typedef struct packed {
        logic volt;
        logic cur;
    } chsel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_START,
        ST_WAIT
    } seq_st_t;

    typedef struct packed {
        res_t   volt_res;
        res_t   cur_res;
        chsel_t sel;
    } result_t;

    function automatic byte_t hi_part(input res_t r);
        return r[RES_W-1:NIB_W];
    endfunction

    function automatic logic [NIB_W-1:0] lo_part(input res_t r);
        return r[NIB_W-1:0];
    endfunction

    function automatic byte_t pack_byte(input result_t res, input logic [1:0] idx);
        byte_t b;
        res_t  single;
        single = res.sel.volt ? res.volt_res : res.cur_res;
        b = '0;
        if (res.sel.volt && res.sel.cur) begin
            case (idx)
                2'd0:    b = hi_part(res.volt_res);
                2'd1:    b = hi_part(res.cur_res);
                2'd2:    b = {lo_part(res.volt_res), lo_part(res.cur_res)};
                default: b = '0;
            endcase
        end else begin
            case (idx)
                2'd0:    b = hi_part(single);
                2'd1:    b = {lo_part(single), {(BYTE_W-NIB_W){1'b0}}};
                default: b = '0;
            endcase
        end
        return b;
    endfunction

    function automatic logic [1:0] byte_count(input chsel_t s);
        return (s.volt && s.cur) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/cseq_trig.sv
module cseq_trig
    import cseq_pkg::*;
#(
    parameter int     SYNC_STAGES = 2,
    parameter chsel_t PIN_SEL     = 2'b11
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_valid,
    input  chsel_t cmd_sel,
    input  logic   conv_pin,
    input  logic   idle,
    output logic   fire,
    output chsel_t fire_sel
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_rise;
    logic                   cmd_ok;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= conv_pin;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
        cmd_ok   = cmd_valid & (cmd_sel != 2'b00);
        fire     = idle & (cmd_ok | pin_rise);
        fire_sel = cmd_ok ? cmd_sel : PIN_SEL;
    end

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
    import cseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  chsel_t  fire_sel,
    input  logic    adc_done,
    input  res_t    adc_data,
    output logic    idle,
    output logic    adc_mux,
    output logic    adc_start,
    output logic    busy,
    output logic    done,
    output result_t res
);
    seq_st_t st_q;
    logic    mux_q, busy_q, done_q;
    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mux_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (fire) begin
                        busy_q    <= 1'b1;
                        done_q    <= 1'b0;
                        res_q.sel <= fire_sel;
                        mux_q     <= fire_sel.volt;
                        st_q      <= ST_SETTLE;
                    end
                end
                ST_SETTLE: st_q <= ST_START;
                ST_START:  st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (adc_done) begin
                        if (mux_q) res_q.volt_res <= adc_data;
                        else       res_q.cur_res  <= adc_data;
                        if (mux_q && res_q.sel.cur) begin
                            mux_q <= 1'b0;
                            st_q  <= ST_SETTLE;
                        end else begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (st_q == ST_IDLE);
        adc_start = (st_q == ST_START);
        adc_mux   = mux_q;
        busy      = busy_q;
        done      = done_q;
        res       = res_q;
    end

endmodule

// File: rtl/cseq_pack.sv
module cseq_pack
    import cseq_pkg::*;
(
    input  result_t    res,
    input  logic       valid,
    input  logic [1:0] idx,
    output byte_t      data,
    output logic [1:0] len
);
    always_comb begin
        data = valid ? pack_byte(res, idx) : '0;
        len  = valid ? byte_count(res.sel) : 2'd0;
    end
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq
    import cseq_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] PIN_SEL     = 2'b11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_sel,
    input  logic        conv_pin,
    output logic        adc_mux,
    output logic        adc_start,
    input  logic        adc_done,
    input  logic [11:0] adc_data,
    output logic        busy,
    output logic        done,
    input  logic [1:0]  rd_idx,
    output logic [7:0]  rd_data,
    output logic [1:0]  rd_len
);
    logic    idle, fire;
    chsel_t  fire_sel;
    result_t res;

    cseq_trig #(.SYNC_STAGES(SYNC_STAGES), .PIN_SEL(PIN_SEL)) u_trig (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .conv_pin(conv_pin), .idle(idle), .fire(fire), .fire_sel(fire_sel)
    );

    cseq_fsm u_fsm (
        .clk(clk), .rst(rst), .fire(fire), .fire_sel(fire_sel),
        .adc_done(adc_done), .adc_data(adc_data), .idle(idle),
        .adc_mux(adc_mux), .adc_start(adc_start), .busy(busy),
        .done(done), .res(res)
    );

    cseq_pack u_pack (
        .res(res), .valid(done), .idx(rd_idx), .data(rd_data), .len(rd_len)
    );

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_sel,
    input logic       adc_mux,
    input logic       adc_start,
    input logic       busy,
    input logic       done,
    input logic [7:0] rd_data,
    input logic [1:0] rd_len
);
    AST_CMD_STARTS_RUN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_sel != 2'b00 && !busy) |=> (busy && !done)); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start); // R5

    AST_MUX_SETTLED: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> $stable(adc_mux)); // R5

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> busy); // R6

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8

    AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (rst)
        !done |-> (rd_data == 8'h00 && rd_len == 2'd0)); // R9
endmodule

bind dual_conv_seq cseq_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .adc_mux(adc_mux), .adc_start(adc_start), .busy(busy), .done(done),
    .rd_data(rd_data), .rd_len(rd_len)
);

// File: tb/dual_conv_seq_test.sv
module dual_conv_seq_test;
    localparam int SYNC = 2;
    localparam int LAT  = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_sel;
    logic        conv_pin;
    logic        adc_mux, adc_start, adc_done;
    logic [11:0] adc_data;
    logic        busy, done;
    logic [1:0]  rd_idx;
    logic [7:0]  rd_data;
    logic [1:0]  rd_len;

    int n_tests = 0;
    int n_fail  = 0;
    logic [11:0] vval, ival;
    bit exp_mux[$];

    always #5 clk = ~clk;

    dual_conv_seq #(.SYNC_STAGES(SYNC), .PIN_SEL(2'b11)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .conv_pin(conv_pin), .adc_mux(adc_mux), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .busy(busy), .done(done),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ADC model and scoreboard monitor: each start pops the expected channel
    initial begin
        adc_done = 1'b0;
        adc_data = '0;
        forever begin
            @(negedge clk);
            if (adc_start) begin
                if (exp_mux.size() == 0) begin
                    chk(1'b0, "R6 unexpected adc_start", 1, 0);
                end else begin
                    automatic bit e = exp_mux.pop_front();
                    chk(adc_mux == e, "R4 channel order", adc_mux, e);
                end
                repeat (LAT) @(negedge clk);
                adc_data = adc_mux ? vval : ival;
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic push_run(input logic [1:0] sel);
        if (sel[1]) exp_mux.push_back(1'b1);
        if (sel[0]) exp_mux.push_back(1'b0);
    endtask

    task automatic send_cmd(input logic [1:0] sel);
        cmd_sel   = sel;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!busy && t < 50) begin @(negedge clk); t++; end
        while (!done && t < 300) begin @(negedge clk); t++; end
        chk(done == 1'b1, req, done, 1);
        chk(exp_mux.size() == 0, {req, " all channels converted"}, exp_mux.size(), 0);
    endtask

    task automatic check_bytes(input string req, input logic [1:0] len,
                               input logic [7:0] b0, input logic [7:0] b1,
                               input logic [7:0] b2);
        logic [7:0] e[4];
        e[0] = b0; e[1] = b1; e[2] = b2; e[3] = 8'h00;
        chk(rd_len == len, {req, " rd_len"}, rd_len, len);
        for (int k = 0; k < 4; k++) begin
            rd_idx = k[1:0];
            #1;
            chk(rd_data == e[k], {req, " byte"}, rd_data, e[k]);
        end
        rd_idx = 2'd0;
    endtask

    initial begin
        #2000000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_sel = 2'b00; conv_pin = 1'b0;
        rd_idx = 2'd0; vval = '0; ival = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(adc_start == 1'b0, "R1 adc_start", adc_start, 0);
        check_bytes("R1", 2'd0, 8'h00, 8'h00, 8'h00);

        // R2/R10 current only
        ival = 12'hABC;
        push_run(2'b01);
        send_cmd(2'b01);
        chk(busy == 1'b1, "R2 busy after command", busy, 1);
        chk(done == 1'b0, "R8 done cleared at start", done, 0);
        chk(rd_data == 8'h00, "R9 no data while running", rd_data, 0);
        wait_done("R8 current run");
        check_bytes("R10 current", 2'd2, 8'hAB, 8'hC0, 8'h00);

        // R10 voltage only
        vval = 12'h5A3;
        push_run(2'b10);
        send_cmd(2'b10);
        wait_done("R8 voltage run");
        check_bytes("R10 voltage", 2'd2, 8'h5A, 8'h30, 8'h00);

        // R11 both, with R6 triggers while busy
        vval = 12'h123; ival = 12'hFED;
        push_run(2'b11);
        send_cmd(2'b11);
        repeat (3) @(negedge clk);
        send_cmd(2'b01);
        conv_pin = 1'b1;
        wait_done("R4 both run");
        check_bytes("R11 both", 2'd3, 8'h12, 8'hFE, 8'h3D);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R6 busy-time triggers dropped", busy, 0);

        // R2 empty channel set
        send_cmd(2'b00);
        chk(busy == 1'b0, "R2 empty select starts nothing", busy, 0);
        chk(done == 1'b1, "R2 done kept", done, 1);

        // R12 stray adc_done while idle
        adc_data = 12'hFFF; adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        check_bytes("R12 stray done", 2'd3, 8'h12, 8'hFE, 8'h3D);

        // R3 pin trigger
        conv_pin = 1'b0;
        repeat (4) @(negedge clk);
        vval = 12'h8F1; ival = 12'h0E7;
        push_run(2'b11);
        conv_pin = 1'b1;
        wait_done("R3 pin run");
        check_bytes("R3 pin", 2'd3, 8'h8F, 8'h0E, 8'h17);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R3 held pin no retrigger", busy, 0);
        chk(done == 1'b1, "R3 held pin done kept", done, 1);

        // R7 command and pin edge in the same cycle
        conv_pin = 1'b0;
        repeat (4) @(negedge clk);
        ival = 12'h321;
        push_run(2'b01);
        conv_pin = 1'b1;
        repeat (SYNC) @(negedge clk);
        send_cmd(2'b01);
        wait_done("R7 collision run");
        check_bytes("R7 command wins", 2'd2, 8'h32, 8'h10, 8'h00);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R7 pin edge discarded", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule